// File: doc/BRIEF.md
# GPIO Bank Register File and Pin Datapath

This block is the software-visible register file of one bank of general-purpose pins, together with the logic that turns those registers into pin drive and samples the pins back. A simple word-wide memory-mapped bus presents an address, a write enable and write data, and receives registered read data one cycle after the address. The block stores direction, output data, pin mode, polarity, trigger kind, dual-edge, filter enable, output source and input enable bits per pin. It drives the per-pin output enables and output values, and brings the pin inputs in through a two-flop synchroniser that is gated per pin.

A separate interrupt sense unit sits beside this block. This block hands it the configuration bits, the synchronised inputs and write strobes for its clear, mask and unmask operations, and returns that unit's pending status and mask vectors on bus reads. Pin multiplexing and chatter filtering timing are outside this block; the filter enable bits are only stored and passed on.

Top module: `gpio_bank_regs`

## Requirements
- R1: While reset is held and after it, every stored register is 0 except input enable, which resets to all ones; no pin is driven (pin_oe = 0, pin_out = 0) and bus_rdata is 0.
- R2: The writable registers sit at byte offsets 0x00 pin mode (1 = interrupt, 0 = general I/O), 0x04 direction, 0x08 output data, 0x20 polarity, 0x24 trigger kind, 0x28 filter enable, 0x40 output source, 0x4C dual edge and 0x50 input enable; each reads back exactly the value last written to it.
- R3: Pin i is driven (pin_oe[i] = 1) only when its direction bit is 1, its mode bit is 0 and its output source bit is 0; when driven pin_out[i] equals output data bit i, otherwise it is 0. Both follow a register write on the next cycle.
- R4: A read of offset 0x0C returns the synchronised pin level whatever the pin direction, correct for a read address presented two or more cycles after the pin settles.
- R5: A pin whose input enable bit is 0 reads 0 at offset 0x0C and on sense_in.
- R6: bus_rdata holds the data for the address presented in the previous cycle.
- R7: Reads of any unmapped or unaligned offset, and of the write-only offsets 0x14 and 0x1C, return 0; writes to unmapped offsets, to 0x0C and to 0x10 change no register.
- R8: A write to 0x14 puts bus_wdata on sense_clr in that cycle, a write to 0x1C puts it on sense_unmask, and a write to 0x18 raises sense_mask_we with bus_wdata on sense_mask_data; in all other cycles these outputs are 0.
- R9: Reads of 0x10 return sense_status and reads of 0x18 return sense_mask, as sampled at the read.
- R10: cfg_irq_mode, cfg_polarity, cfg_edge, cfg_dual and cfg_filter carry the mode, polarity, trigger kind, dual edge and filter enable registers.
- R11: sense_in carries the gated synchronised pin inputs two cycles after the pins settle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Raw pin levels |
| pin_oe | output | 32 | Per-pin output enable |
| pin_out | output | 32 | Per-pin output value |
| sense_in | output | 32 | Gated synchronised inputs for the sense unit |
| cfg_irq_mode | output | 32 | Per-pin interrupt mode select |
| cfg_polarity | output | 32 | Per-pin inverted-logic select |
| cfg_edge | output | 32 | Per-pin edge (1) or level (0) trigger |
| cfg_dual | output | 32 | Per-pin dual-edge select |
| cfg_filter | output | 32 | Per-pin filter enable |
| sense_clr | output | 32 | Pending-clear bits, valid in the write cycle |
| sense_unmask | output | 32 | Unmask bits, valid in the write cycle |
| sense_mask_we | output | 1 | Mask register write strobe |
| sense_mask_data | output | 32 | Mask register write data |
| sense_status | input | 32 | Pending status from the sense unit |
| sense_mask | input | 32 | Mask register of the sense unit |

## Verification
A wrong stored bit shows at the ports one cycle after the write that set it: at once on pin_oe, pin_out or a cfg output, and on bus_rdata one cycle after any read of that offset. A fault in the synchroniser or its gating shows two cycles after a pin change, on sense_in and on a read of the input offset. A decode fault shows as a wrong strobe in the very cycle of a write, or as nonzero data from an unmapped read one cycle later.

// File: rtl/gpio_bank_pkg.sv
// Shared offsets and register select codes for the GPIO bank.
// Assumes word-aligned byte offsets; anything else decodes to SEL_NONE.
package gpio_bank_pkg;

    localparam logic [31:0] OFS_MODE   = 32'h00;
    localparam logic [31:0] OFS_DIR    = 32'h04;
    localparam logic [31:0] OFS_ODATA  = 32'h08;
    localparam logic [31:0] OFS_IDATA  = 32'h0C;
    localparam logic [31:0] OFS_STAT   = 32'h10;
    localparam logic [31:0] OFS_CLR    = 32'h14;
    localparam logic [31:0] OFS_MASK   = 32'h18;
    localparam logic [31:0] OFS_UNMASK = 32'h1C;
    localparam logic [31:0] OFS_POL    = 32'h20;
    localparam logic [31:0] OFS_EDGE   = 32'h24;
    localparam logic [31:0] OFS_FILT   = 32'h28;
    localparam logic [31:0] OFS_OSRC   = 32'h40;
    localparam logic [31:0] OFS_DUAL   = 32'h4C;
    localparam logic [31:0] OFS_INEN   = 32'h50;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_DIR,
        SEL_ODATA,
        SEL_IDATA,
        SEL_STAT,
        SEL_CLR,
        SEL_MASK,
        SEL_UNMASK,
        SEL_POL,
        SEL_EDGE,
        SEL_FILT,
        SEL_OSRC,
        SEL_DUAL,
        SEL_INEN
    } reg_sel_e;

    // Map a zero-extended byte address to a register select.
    function automatic reg_sel_e decode_addr(input logic [31:0] addr);
        reg_sel_e sel;
        case (addr)
            OFS_MODE:   sel = SEL_MODE;
            OFS_DIR:    sel = SEL_DIR;
            OFS_ODATA:  sel = SEL_ODATA;
            OFS_IDATA:  sel = SEL_IDATA;
            OFS_STAT:   sel = SEL_STAT;
            OFS_CLR:    sel = SEL_CLR;
            OFS_MASK:   sel = SEL_MASK;
            OFS_UNMASK: sel = SEL_UNMASK;
            OFS_POL:    sel = SEL_POL;
            OFS_EDGE:   sel = SEL_EDGE;
            OFS_FILT:   sel = SEL_FILT;
            OFS_OSRC:   sel = SEL_OSRC;
            OFS_DUAL:   sel = SEL_DUAL;
            OFS_INEN:   sel = SEL_INEN;
            default:    sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop input synchroniser with a per-pin sample gate.
// Assumes pin_in is asynchronous; a gated pin loads 0 into both stages,
// and the output is masked again so that disabling takes effect at once.
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] gate,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Two-stage capture of gated pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= pin_in & gate;
            stage2 <= stage1 & gate;
        end
    end

    // Present only enabled pins.
    assign sync_out = stage2 & gate;

endmodule

// File: rtl/gpio_cfg_regs.sv
// Storage for the writable configuration registers of the bank.
// Assumes wr_sel is already decoded; read-only and strobe selects store nothing.
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int          N_PINS   = 32,
    parameter logic [31:0] INEN_RST = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [N_PINS-1:0] wr_data,
    output logic [N_PINS-1:0] r_mode,
    output logic [N_PINS-1:0] r_dir,
    output logic [N_PINS-1:0] r_odata,
    output logic [N_PINS-1:0] r_pol,
    output logic [N_PINS-1:0] r_edge,
    output logic [N_PINS-1:0] r_filt,
    output logic [N_PINS-1:0] r_osrc,
    output logic [N_PINS-1:0] r_dual,
    output logic [N_PINS-1:0] r_inen
);

    localparam logic [N_PINS-1:0] INEN_INIT = INEN_RST[N_PINS-1:0];

    // Load the addressed register on a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_mode  <= '0;
            r_dir   <= '0;
            r_odata <= '0;
            r_pol   <= '0;
            r_edge  <= '0;
            r_filt  <= '0;
            r_osrc  <= '0;
            r_dual  <= '0;
            r_inen  <= INEN_INIT;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_MODE:  r_mode  <= wr_data;
                SEL_DIR:   r_dir   <= wr_data;
                SEL_ODATA: r_odata <= wr_data;
                SEL_POL:   r_pol   <= wr_data;
                SEL_EDGE:  r_edge  <= wr_data;
                SEL_FILT:  r_filt  <= wr_data;
                SEL_OSRC:  r_osrc  <= wr_data;
                SEL_DUAL:  r_dual  <= wr_data;
                SEL_INEN:  r_inen  <= wr_data;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_pin_drive.sv
// Per-pin output drive: a pin drives only in general I/O mode, as an output,
// with the output data register selected as its source.
module gpio_pin_drive #(
    parameter int N_PINS = 32
) (
    input  logic [N_PINS-1:0] r_mode,
    input  logic [N_PINS-1:0] r_dir,
    input  logic [N_PINS-1:0] r_osrc,
    input  logic [N_PINS-1:0] r_odata,
    output logic [N_PINS-1:0] pin_oe,
    output logic [N_PINS-1:0] pin_out
);

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic drive;
        // Qualify the drive of pin i.
        always_comb drive = r_dir[i] & ~r_mode[i] & ~r_osrc[i];
        assign pin_oe[i]  = drive;
        assign pin_out[i] = drive & r_odata[i];
    end

endmodule

// File: rtl/gpio_rd_mux.sv
// Registered read data selection. Unmapped and write-only selects give 0.
module gpio_rd_mux
    import gpio_bank_pkg::*;
#(
    parameter int N_PINS = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          rd_sel,
    input  logic [N_PINS-1:0] r_mode,
    input  logic [N_PINS-1:0] r_dir,
    input  logic [N_PINS-1:0] r_odata,
    input  logic [N_PINS-1:0] in_data,
    input  logic [N_PINS-1:0] status,
    input  logic [N_PINS-1:0] mask,
    input  logic [N_PINS-1:0] r_pol,
    input  logic [N_PINS-1:0] r_edge,
    input  logic [N_PINS-1:0] r_filt,
    input  logic [N_PINS-1:0] r_osrc,
    input  logic [N_PINS-1:0] r_dual,
    input  logic [N_PINS-1:0] r_inen,
    output logic [DATA_W-1:0] rdata
);

    logic [N_PINS-1:0] pick;

    // Select the field for the addressed register.
    always_comb begin
        case (rd_sel)
            SEL_MODE:  pick = r_mode;
            SEL_DIR:   pick = r_dir;
            SEL_ODATA: pick = r_odata;
            SEL_IDATA: pick = in_data;
            SEL_STAT:  pick = status;
            SEL_MASK:  pick = mask;
            SEL_POL:   pick = r_pol;
            SEL_EDGE:  pick = r_edge;
            SEL_FILT:  pick = r_filt;
            SEL_OSRC:  pick = r_osrc;
            SEL_DUAL:  pick = r_dual;
            SEL_INEN:  pick = r_inen;
            default:   pick = '0;
        endcase
    end

    // Register the read data, zero-extended to the bus width.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= DATA_W'(pick);
    end

endmodule

// File: rtl/gpio_bank_regs.sv
// Top of the GPIO bank register file and pin datapath.
// Assumes N_PINS <= DATA_W and a single-cycle bus with no wait states.
// The interrupt sense unit is external; this block only forwards
// configuration and strobes to it and reads back its status and mask.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int          N_PINS   = 32,
    parameter int          DATA_W   = 32,
    parameter int          ADDR_W   = 8,
    parameter logic [31:0] INEN_RST = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_oe,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] sense_in,
    output logic [N_PINS-1:0] cfg_irq_mode,
    output logic [N_PINS-1:0] cfg_polarity,
    output logic [N_PINS-1:0] cfg_edge,
    output logic [N_PINS-1:0] cfg_dual,
    output logic [N_PINS-1:0] cfg_filter,
    output logic [N_PINS-1:0] sense_clr,
    output logic [N_PINS-1:0] sense_unmask,
    output logic              sense_mask_we,
    output logic [N_PINS-1:0] sense_mask_data,
    input  logic [N_PINS-1:0] sense_status,
    input  logic [N_PINS-1:0] sense_mask
);

    reg_sel_e          sel;
    logic [N_PINS-1:0] wdata_p;
    logic [N_PINS-1:0] r_mode, r_dir, r_odata, r_pol, r_edge;
    logic [N_PINS-1:0] r_filt, r_osrc, r_dual, r_inen;
    logic [N_PINS-1:0] in_data;

    // Decode the bus address once for both write and read paths.
    always_comb sel = decode_addr(32'(bus_addr));
    assign wdata_p = bus_wdata[N_PINS-1:0];

    gpio_cfg_regs #(
        .N_PINS   (N_PINS),
        .INEN_RST (INEN_RST)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .wr_sel  (sel),
        .wr_data (wdata_p),
        .r_mode  (r_mode),
        .r_dir   (r_dir),
        .r_odata (r_odata),
        .r_pol   (r_pol),
        .r_edge  (r_edge),
        .r_filt  (r_filt),
        .r_osrc  (r_osrc),
        .r_dual  (r_dual),
        .r_inen  (r_inen)
    );

    gpio_pin_drive #(
        .N_PINS (N_PINS)
    ) u_drive (
        .r_mode  (r_mode),
        .r_dir   (r_dir),
        .r_osrc  (r_osrc),
        .r_odata (r_odata),
        .pin_oe  (pin_oe),
        .pin_out (pin_out)
    );

    gpio_in_sync #(
        .W (N_PINS)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .gate     (r_inen),
        .sync_out (in_data)
    );

    gpio_rd_mux #(
        .N_PINS (N_PINS),
        .DATA_W (DATA_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_sel  (sel),
        .r_mode  (r_mode),
        .r_dir   (r_dir),
        .r_odata (r_odata),
        .in_data (in_data),
        .status  (sense_status),
        .mask    (sense_mask),
        .r_pol   (r_pol),
        .r_edge  (r_edge),
        .r_filt  (r_filt),
        .r_osrc  (r_osrc),
        .r_dual  (r_dual),
        .r_inen  (r_inen),
        .rdata   (bus_rdata)
    );

    // Forward configuration to the sense unit.
    assign sense_in     = in_data;
    assign cfg_irq_mode = r_mode;
    assign cfg_polarity = r_pol;
    assign cfg_edge     = r_edge;
    assign cfg_dual     = r_dual;
    assign cfg_filter   = r_filt;

    // Single-cycle strobes for the sense unit's write-only operations.
    always_comb begin
        sense_clr       = '0;
        sense_unmask    = '0;
        sense_mask_we   = 1'b0;
        sense_mask_data = '0;
        if (bus_we) begin
            case (sel)
                SEL_CLR:    sense_clr = wdata_p;
                SEL_UNMASK: sense_unmask = wdata_p;
                SEL_MASK: begin
                    sense_mask_we   = 1'b1;
                    sense_mask_data = wdata_p;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_bank_regs_chk.sv
// Property checker for gpio_bank_regs, attached by bind below.
module gpio_bank_regs_chk
    import gpio_bank_pkg::*;
#(
    parameter int N_PINS = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N_PINS-1:0] pin_oe,
    input logic [N_PINS-1:0] pin_out,
    input logic [N_PINS-1:0] sense_clr,
    input logic [N_PINS-1:0] sense_unmask
);

    reg_sel_e sel_c;
    always_comb sel_c = decode_addr(32'(bus_addr));

    // R3
    dir_clear_undrives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel_c == SEL_DIR) |=> ((pin_oe & ~$past(bus_wdata[N_PINS-1:0])) == '0));

    // R7
    ro_write_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (sel_c == SEL_IDATA || sel_c == SEL_STAT || sel_c == SEL_NONE))
        |=> ($stable(pin_oe) && $stable(pin_out)));

    // R7
    unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_c == SEL_NONE || sel_c == SEL_CLR || sel_c == SEL_UNMASK) |=> (bus_rdata == '0));

    // R2
    odata_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && sel_c == SEL_ODATA && $past(bus_we && sel_c == SEL_ODATA))
        |=> (bus_rdata == DATA_W'($past(bus_wdata[N_PINS-1:0], 2))));

    // R8
    clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && sel_c == SEL_CLR) |-> (sense_clr == '0));

    // R8
    unmask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && sel_c == SEL_UNMASK) |-> (sense_unmask == '0));

    // R3
    out_only_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
    .N_PINS (N_PINS),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pin_oe       (pin_oe),
    .pin_out      (pin_out),
    .sense_clr    (sense_clr),
    .sense_unmask (sense_unmask)
);

// File: tb/gpio_bank_regs_bench.sv
module gpio_bank_regs_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_oe, pin_out, sense_in;
    logic [31:0] cfg_irq_mode, cfg_polarity, cfg_edge, cfg_dual, cfg_filter;
    logic [31:0] sense_clr, sense_unmask, sense_mask_data;
    logic        sense_mask_we;
    logic [31:0] sense_status = '0;
    logic [31:0] sense_mask = '0;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] shadow [0:31];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_regs u_gpio_bank_regs (
        .clk (clk), .rst_n (rst_n),
        .bus_addr (bus_addr), .bus_we (bus_we), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in (pin_in), .pin_oe (pin_oe), .pin_out (pin_out),
        .sense_in (sense_in),
        .cfg_irq_mode (cfg_irq_mode), .cfg_polarity (cfg_polarity),
        .cfg_edge (cfg_edge), .cfg_dual (cfg_dual), .cfg_filter (cfg_filter),
        .sense_clr (sense_clr), .sense_unmask (sense_unmask),
        .sense_mask_we (sense_mask_we), .sense_mask_data (sense_mask_data),
        .sense_status (sense_status), .sense_mask (sense_mask)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit is_writable(input logic [7:0] a);
        return a == 8'h00 || a == 8'h04 || a == 8'h08 || a == 8'h20 || a == 8'h24 ||
               a == 8'h28 || a == 8'h40 || a == 8'h4C || a == 8'h50;
    endfunction

    // Expected read value from the requirements (R2, R4, R5, R7, R9).
    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (is_writable(a)) return shadow[a[6:2]];
        if (a == 8'h0C)     return pin_in & shadow[8'h50 >> 2];
        if (a == 8'h10)     return sense_status;
        if (a == 8'h18)     return sense_mask;
        return 32'h0;
    endfunction

    function automatic logic [31:0] exp_oe();
        return shadow[1] & ~shadow[0] & ~shadow[8'h40 >> 2];
    endfunction

    // Write at a negedge; the register loads at the following posedge.
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        if (is_writable(a)) shadow[a[6:2]] = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // Present the address, then compare the registered data one cycle later (R6).
    task automatic bus_read(input logic [7:0] a, input string req);
        logic [31:0] e;
        bus_addr = a; bus_we = 1'b0;
        e = exp_read(a);
        @(posedge clk);
        @(negedge clk);
        check(req, bus_rdata, e);
    endtask

    task automatic check_pins(input string req);
        check(req, pin_oe, exp_oe());
        check(req, pin_out, exp_oe() & shadow[2]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [7:0] wlist [0:8];
        logic [7:0] ulist [0:7];
        int unsigned seed;
        seed = 32'd2718;
        void'($urandom(seed));
        wlist = '{8'h00, 8'h04, 8'h08, 8'h20, 8'h24, 8'h28, 8'h40, 8'h4C, 8'h50};
        ulist = '{8'h2C, 8'h30, 8'h44, 8'h48, 8'h54, 8'hFC, 8'h05, 8'h0C};
        for (int i = 0; i < 32; i++) shadow[i] = 32'h0;
        shadow[8'h50 >> 2] = 32'hFFFF_FFFF;

        // R1: state while reset is held.
        pin_in = 32'hA5A5_0F0F;
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", bus_rdata, 32'h0);
        check("R1 oe in reset", pin_oe, 32'h0);
        check("R1 out in reset", pin_out, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2: every register reads its reset value.
        for (int i = 0; i < 9; i++) bus_read(wlist[i], "R1 reset value");
        check("R10 cfg after reset", cfg_irq_mode | cfg_polarity | cfg_edge | cfg_dual | cfg_filter, 32'h0);

        // R3: directed drive combinations.
        bus_write(8'h08, 32'hFFFF_0000);
        bus_write(8'h04, 32'h00FF_00FF);
        check_pins("R3 output drive");
        bus_write(8'h00, 32'h0000_000F);
        check_pins("R3 interrupt mode blocks drive");
        bus_write(8'h40, 32'h00F0_0000);
        check_pins("R3 output source blocks drive");

        // R4: input data follows pins even for driven pins.
        pin_in = 32'h1234_5678;
        repeat (2) @(negedge clk);
        bus_read(8'h0C, "R4 input on output pins");
        check("R11 sense_in", sense_in, 32'h1234_5678);

        // R5: disabled inputs read 0.
        bus_write(8'h50, 32'h0000_FFFF);
        check("R5 sense_in gated", sense_in, 32'h0000_5678);
        bus_read(8'h0C, "R5 input gated");

        // R8: strobes during the write cycle.
        bus_addr = 8'h14; bus_we = 1'b1; bus_wdata = 32'hDEAD_0001;
        #1 check("R8 clear strobe", sense_clr, 32'hDEAD_0001);
        check("R8 unmask quiet", sense_unmask, 32'h0);
        @(negedge clk);
        bus_addr = 8'h1C; bus_wdata = 32'h0000_0300;
        #1 check("R8 unmask strobe", sense_unmask, 32'h0000_0300);
        @(negedge clk);
        bus_addr = 8'h18; bus_wdata = 32'h8000_0001;
        #1 check("R8 mask strobe", {31'h0, sense_mask_we}, 32'h1);
        check("R8 mask data", sense_mask_data, 32'h8000_0001);
        @(negedge clk);
        bus_we = 1'b0;
        #1 check("R8 idle strobes", sense_clr | sense_unmask | {31'h0, sense_mask_we}, 32'h0);
        @(negedge clk);

        // R7, R9: write-only, status and mask reads.
        sense_status = 32'h0BAD_F00D; sense_mask = 32'h0000_FF00;
        bus_read(8'h14, "R7 clear reads 0");
        bus_read(8'h1C, "R7 unmask reads 0");
        bus_read(8'h10, "R9 status read");
        bus_read(8'h18, "R9 mask read");

        // Random mix.
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0, 1: begin
                    logic [7:0] a;
                    a = wlist[$urandom % 9];
                    bus_write(a, $urandom);
                    check_pins("R3 random drive");
                    check("R10 cfg mode", cfg_irq_mode, shadow[0]);
                    check("R10 cfg polarity", cfg_polarity, shadow[8]);
                    check("R10 cfg edge", cfg_edge, shadow[9]);
                    check("R10 cfg filter", cfg_filter, shadow[10]);
                    check("R10 cfg dual", cfg_dual, shadow[19]);
                end
                2: bus_read(wlist[$urandom % 9], "R2 random readback");
                3: begin
                    pin_in = $urandom;
                    repeat (2) @(negedge clk);
                    check("R11 random sense_in", sense_in, pin_in & shadow[20]);
                    bus_read(8'h0C, "R4 R5 random input");
                end
                4: begin
                    sense_status = $urandom; sense_mask = $urandom;
                    bus_read(($urandom % 2) ? 8'h10 : 8'h18, "R9 random sense read");
                end
                default: begin
                    logic [7:0] u;
                    u = ulist[$urandom % 8];
                    bus_write(u, $urandom);
                    check_pins("R7 ignored write");
                    bus_read(u, "R7 unmapped or read-only");
                    bus_read(wlist[$urandom % 9], "R7 registers unchanged");
                end
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule